// File: doc/BRIEF.md
# Per-Pixel Two-Stage Hit Timer

This block timestamps a single hit in one pixel against a slow clock that is shared across the whole array. A hit opens a local fast oscillator window. The window closes at the next rising edge of the slow clock, and a fine counter records how many fast cycles fit inside it. From that same slow edge, a coarse counter counts slow periods until a read/trigger arrives. The arrival time within a slow period is the slow period minus the fine count times the fast period. The full reading is the coarse count in slow periods plus the fine count in fast periods.

Two clocks drive the block. `clk_slow` is the distributed clock. `clk_fast` stands in for the local oscillator and is treated as an unrelated clock domain. `osc_en` reports when the oscillator window is open. The fine result reaches the slow domain through a two-flop synchronized completion flag, and only then is the word flagged valid.

A clear-mode select controls a pixel that holds a measurement but receives no read. With the select high, the pixel clears itself after a fixed number of slow periods. With it low, the pixel keeps its data until a read or a reset.

Top module: `pixel_hit_timer`

## Requirements
- R1: `rst` is asynchronous and active high. While it is high, `word_valid`, `osc_en` and `time_word` are 0, and the block returns to idle.
- R2: In idle, a `hit` sampled high on a `clk_fast` rising edge raises `osc_en` on that edge. `osc_en` stays high across the next `clk_slow` rising edge and falls on the third `clk_fast` edge after that slow edge.
- R3: The fine count covers the `clk_fast` rising edges after the hit-capturing edge, up to and including the second edge after the stopping slow edge. It saturates at 15 and does not wrap.
- R4: The coarse count is the number of `clk_slow` rising edges after the stopping edge, up to and including the edge that samples `read_trig` high. It saturates at 15.
- R5: `time_word[7:4]` holds the coarse count and `time_word[3:0]` holds the fine count. `time_word` is 0 whenever `word_valid` is low, and it is stable while `word_valid` stays high.
- R6: After the read edge, `word_valid` rises only once the fine-count completion has passed two `clk_slow` flops. It stays high until the next `read_trig`, which returns the pixel to idle.
- R7: With `clear_on` high, if the coarse count has reached 14 and the next slow edge brings no read, the pixel returns to idle on that edge without ever asserting `word_valid`. A read sampled on that edge is still accepted and gives a coarse count of 15. With `clear_on` low, the pixel waits indefinitely.
- R8: A `hit` that arrives while a measurement is counting or held does not raise `osc_en` and does not change the word that is reported.
- R9: A `read_trig` that arrives while the pixel is idle has no effect: `word_valid` stays low and a later hit is measured normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_slow | input | 1 | Distributed slow clock; the stop reference and the coarse count clock |
| clk_fast | input | 1 | Local oscillator stand-in; the fine count clock |
| rst | input | 1 | Asynchronous reset, active high |
| hit | input | 1 | Hit pulse from the front-end |
| read_trig | input | 1 | Read/trigger; freezes a running measurement or releases a held one |
| clear_on | input | 1 | 1 selects self-clear after the timeout, 0 selects hold forever |
| time_word | output | 8 | {coarse count, fine count} |
| word_valid | output | 1 | The word holds a completed measurement |
| osc_en | output | 1 | The oscillator window is open |

## Verification
The hardest case to reach is the fine count at its limits: a hit that lands just before a slow edge, and a hit that lands a full slow period earlier so that the counter saturates. To reach both, the stimulus steps the hit across every fast-clock position inside one slow period, and the expected fine value for each position is worked out from the offset. The coarse count is swept separately up to and past saturation and into the self-clear boundary. Hits arriving while a measurement is running or held, and reset asserted while the window is open, are driven at fixed offsets from the slow edge.

// File: rtl/pixel_hit_timer.sv
module pixel_hit_timer #(
  parameter int CW      = 4,
  parameter int TIMEOUT = 14
) (
  input  logic            clk_slow,
  input  logic            clk_fast,
  input  logic            rst,
  input  logic            hit,
  input  logic            read_trig,
  input  logic            clear_on,
  output logic [2*CW-1:0] time_word,
  output logic            word_valid,
  output logic            osc_en
);
  localparam logic [CW-1:0] CMAX = '1;
  localparam logic [CW-1:0] TLIM = CW'(TIMEOUT);

  typedef enum logic [1:0] {IDLE, RUN, HELD} st_t;

  st_t           st;
  logic [CW-1:0] scnt, fcnt;
  logic          osc_q, fdone, busy_f1, busy_f2, done_s1, done_s2;
  logic          busy;

  assign busy       = (st != IDLE);
  assign osc_en     = osc_q;
  assign word_valid = (st == HELD) && done_s2;
  assign time_word  = word_valid ? {scnt, fcnt} : '0;

  always_ff @(posedge clk_fast or posedge rst) begin
    if (rst) begin
      busy_f1 <= 1'b0;
      busy_f2 <= 1'b0;
      osc_q   <= 1'b0;
      fdone   <= 1'b0;
      fcnt    <= '0;
    end else begin
      busy_f1 <= busy;
      busy_f2 <= busy_f1;
      if (osc_q) begin
        if (busy_f2) begin
          osc_q <= 1'b0;
          fdone <= 1'b1;
        end else if (fcnt != CMAX) begin
          fcnt <= fcnt + 1'b1;
        end
      end else if (!busy_f2) begin
        fdone <= 1'b0;
        if (hit) begin
          osc_q <= 1'b1;
          fcnt  <= '0;
        end
      end
    end
  end

  always_ff @(posedge clk_slow or posedge rst) begin
    if (rst) begin
      st      <= IDLE;
      scnt    <= '0;
      done_s1 <= 1'b0;
      done_s2 <= 1'b0;
    end else begin
      done_s1 <= fdone;
      done_s2 <= done_s1;
      unique case (st)
        IDLE: if (osc_q) begin
          st   <= RUN;
          scnt <= '0;
        end
        RUN: begin
          if (read_trig) begin
            st <= HELD;
            if (scnt != CMAX) scnt <= scnt + 1'b1;
          end else if (clear_on && scnt == TLIM) begin
            st <= IDLE;
          end else if (scnt != CMAX) begin
            scnt <= scnt + 1'b1;
          end
        end
        HELD: if (read_trig) st <= IDLE;
        default: st <= IDLE;
      endcase
    end
  end

  // R2
  osc_excl_chk: assert property (@(posedge clk_fast) disable iff (rst)
    !(osc_q && fdone));

  // R3
  fine_sat_chk: assert property (@(posedge clk_fast) disable iff (rst)
    (osc_q && !busy_f2 && fcnt == CMAX) |=> (fcnt == CMAX));

  // R8
  hit_ignore_chk: assert property (@(posedge clk_fast) disable iff (rst)
    (busy_f2 && !osc_q) |=> !osc_q);

  // R4
  coarse_sat_chk: assert property (@(posedge clk_slow) disable iff (rst)
    (st != IDLE && scnt == CMAX) |=> (scnt == CMAX || st == IDLE));

  // R5
  word_hold_chk: assert property (@(posedge clk_slow) disable iff (rst)
    (word_valid && $past(word_valid)) |-> $stable(time_word));

  // R6
  valid_done_chk: assert property (@(posedge clk_slow) disable iff (rst)
    word_valid |-> fdone);

  // R7
  timeout_chk: assert property (@(posedge clk_slow) disable iff (rst)
    (st == RUN && clear_on && scnt == TLIM && !read_trig) |=> (st == IDLE && !word_valid));
endmodule

// File: tb/pixel_hit_timer_bench.sv
`timescale 1ns/100ps
module pixel_hit_timer_bench;
  logic       clk_slow = 1'b0, clk_fast = 1'b0;
  logic       rst = 1'b1, hit = 1'b0, read_trig = 1'b0, clear_on = 1'b0;
  logic [7:0] time_word;
  logic       word_valid, osc_en;
  int         total = 0, bad = 0;
  bit         finished = 0;

  pixel_hit_timer u_pixel_hit_timer (
    .clk_slow(clk_slow), .clk_fast(clk_fast), .rst(rst), .hit(hit),
    .read_trig(read_trig), .clear_on(clear_on), .time_word(time_word),
    .word_valid(word_valid), .osc_en(osc_en)
  );

  always #10  clk_slow = ~clk_slow;
  always #0.5 clk_fast = ~clk_fast;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $realtime);
    end
  endtask

  function automatic int smin(input int a);
    return (a > 15) ? 15 : a;
  endfunction

  // hit lands d ns before the next slow edge S; after the call time is S+5
  task automatic fire(input int d, input bit expect_osc);
    @(posedge clk_slow);
    #(20 - d) hit = 1'b1;
    #0.8;
    chk(osc_en == expect_osc, "R2/R8 osc_en after hit", osc_en, expect_osc);
    #0.2 hit = 1'b0;
    #(d + 4);
  endtask

  // read high across the n-th slow edge after S, starting from S+5
  task automatic read_at(input int n);
    for (int i = 1; i < n; i++) begin
      @(posedge clk_slow);
      #5;
    end
    read_trig = 1'b1;
    @(posedge clk_slow);
    #5 read_trig = 1'b0;
    #40;
  endtask

  task automatic release_pixel;
    @(posedge clk_slow);
    #5 read_trig = 1'b1;
    @(posedge clk_slow);
    #5 read_trig = 1'b0;
    repeat (4) @(posedge clk_slow);
  endtask

  task automatic measure(input int d, input int n, input bit exp_valid, input string tag);
    int exp_word;
    fire(d, 1'b1);
    chk(osc_en == 1'b0, "R2 osc_en closed after slow edge", osc_en, 0);
    read_at(n);
    exp_word = exp_valid ? ((smin(n) << 4) | smin(d + 1)) : 0;
    chk(word_valid == exp_valid, {tag, " valid"}, word_valid, exp_valid);
    chk(time_word == exp_word, {tag, " word"}, time_word, exp_word);
    release_pixel();
    chk(word_valid == 1'b0, "R6 read releases held word", word_valid, 0);
  endtask

  initial begin
    #100000;
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #5;
    chk(word_valid == 1'b0 && osc_en == 1'b0 && time_word == 8'h00, "R1 reset outputs", time_word, 0);
    #30 rst = 1'b0;
    repeat (3) @(posedge clk_slow);

    // R3 fine count sweep across every fast position, including saturation
    for (int d = 1; d <= 20; d++) measure(d, 2, 1'b1, "R3/R5 fine sweep");

    // R4 coarse count sweep into saturation, hold mode
    clear_on = 1'b0;
    for (int n = 1; n <= 17; n++) measure(3, n, 1'b1, "R4 coarse sweep");

    // R7 self-clear boundary
    clear_on = 1'b1;
    measure(4, 14, 1'b1, "R7 read before timeout");
    measure(4, 15, 1'b1, "R7 read on timeout edge");
    measure(4, 16, 1'b0, "R7 timed out");
    measure(6, 2, 1'b1, "R7 pixel usable after timeout");
    clear_on = 1'b0;

    // R8 hit while counting and while held
    fire(7, 1'b1);
    #2 hit = 1'b1;
    #0.8 chk(osc_en == 1'b0, "R8 hit while counting", osc_en, 0);
    #0.2 hit = 1'b0;
    @(posedge clk_slow);
    #5;
    read_at(2);
    chk(time_word == ((3 << 4) | 8), "R8 word after ignored hit", time_word, (3 << 4) | 8);
    fire(2, 1'b0);
    repeat (3) @(posedge clk_slow);
    #5 chk(word_valid == 1'b1 && time_word == ((3 << 4) | 8), "R8 held word kept", time_word, (3 << 4) | 8);
    release_pixel();

    // R9 read while idle
    read_trig = 1'b1;
    repeat (2) @(posedge clk_slow);
    #5 read_trig = 1'b0;
    repeat (3) @(posedge clk_slow);
    #5 chk(word_valid == 1'b0, "R9 idle read ignored", word_valid, 0);
    measure(9, 3, 1'b1, "R9 measure after idle read");

    // R1 reset while the window is open and while a word is held
    @(posedge clk_slow);
    #5 hit = 1'b1;
    #1 hit = 1'b0;
    #1 chk(osc_en == 1'b1, "R1 window open before reset", osc_en, 1);
    rst = 1'b1;
    #0.2 chk(osc_en == 1'b0, "R1 reset closes window", osc_en, 0);
    #30 rst = 1'b0;
    repeat (3) @(posedge clk_slow);
    fire(5, 1'b1);
    read_at(2);
    chk(word_valid == 1'b1, "R1 valid before reset", word_valid, 1);
    rst = 1'b1;
    #1 chk(word_valid == 1'b0 && time_word == 8'h00, "R1 reset clears word", time_word, 0);
    #30 rst = 1'b0;
    repeat (3) @(posedge clk_slow);
    measure(11, 4, 1'b1, "R1 measure after reset");

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule